// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment selector value and an offset into a flat memory address. It works in one of two addressing modes, chosen per request. In the 16-bit mode, the segment value is scaled by sixteen to give a 20-bit base, and the low sixteen offset bits are added to it. The result wraps inside a 1 MiB space. In the 32-bit mode, the caller supplies a segment descriptor: a 32-bit base, a 20-bit limit and a granularity bit. The unit adds the full 32-bit offset to the base, and rejects any offset that lies past the last valid byte of the segment.

The address logic is combinational and feeds one output register. A request presented with `req_valid` in one cycle gives its result on the outputs in the following cycle. Looking up the descriptor, privilege checking and page translation all happen outside this block.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_out`, `addr_valid` and `limit_fault` are all cleared to 0 in the next cycle, whatever the request inputs are.
- R2: With `mode_prot` = 0 (16-bit mode), the result is `addr_out` = ((`seg_val` × 16) + `offset[15:0]`) mod 2^20, with bits 31:20 zero, `addr_valid` = 1 and `limit_fault` = 0.
- R3: In 16-bit mode, a carry out of address bit 19 is discarded. Examples: FFFFh:0010h gives 00000h, and FFFFh:FFFFh gives 0FFEFh.
- R4: In 16-bit mode, `offset[31:16]`, `desc_base`, `desc_limit` and `desc_gran` have no effect on any output.
- R5: With `mode_prot` = 1 (32-bit mode) and an offset within the limit, `addr_out` = (`desc_base` + `offset`) mod 2^32, `addr_valid` = 1 and `limit_fault` = 0.
- R6: The effective limit is `desc_limit` zero-extended to 32 bits when `desc_gran` = 0. When `desc_gran` = 1, it is {`desc_limit`, 12'hFFF}. Example: base 23000000h with limit 012FFh gives a last byte of 230012FFh when `desc_gran` = 0, and 242FFFFFh when `desc_gran` = 1.
- R7: In 32-bit mode, an offset greater than the effective limit gives `limit_fault` = 1, `addr_valid` = 0 and `addr_out` = 0. An offset equal to the effective limit is accepted.
- R8: Every output reflects the request of the previous cycle. A cycle with `req_valid` = 0 gives all three outputs 0 in the next cycle. `addr_valid` and `limit_fault` are never both 1.
- R9: In 32-bit mode, `seg_val` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A translation request is present this cycle |
| mode_prot | input | 1 | 0: 16-bit scaled-segment mode, 1: 32-bit descriptor mode |
| seg_val | input | 16 | Segment value (used in 16-bit mode) |
| offset | input | 32 | Offset; only bits 15:0 are used in 16-bit mode |
| desc_base | input | 32 | Descriptor base address |
| desc_limit | input | 20 | Descriptor limit field |
| desc_gran | input | 1 | Descriptor granularity: 1 scales the limit by 4 KiB |
| addr_out | output | 32 | Translated address, 0 when no valid result |
| addr_valid | output | 1 | Address on `addr_out` is valid |
| limit_fault | output | 1 | Previous request exceeded the segment limit |

## Verification
The hardest cases are the exact edges of the limit compare in granular mode. An offset of {limit, FFFh} must pass, while {limit, FFFh} + 1 must fault. The compare must also see the low twelve filled bits and not only the upper twenty. The stimulus drives both sides of that edge for both granularity settings, using the descriptor example from the requirements. It also drives base-plus-offset sums that overflow 32 bits and 20 bits, so that both wrap rules are tested. A long run of random requests, mixed with idle cycles, then checks that results stay in cycle order through the scoreboard queue.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_W      = 16;
    localparam int SEG_SHIFT  = 4;
    localparam int REAL_W     = SEG_W + SEG_SHIFT;
    localparam int REAL_OFF_W = 16;
    localparam int OFF_W      = 32;
    localparam int BASE_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int LIM_W      = 20;
    localparam int GRAN_SHIFT = OFF_W - LIM_W;

    typedef enum logic {
        XM_REAL = 1'b0,
        XM_PROT = 1'b1
    } xlate_mode_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              gran;
    } seg_desc_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ok;
        logic              fault;
    } xlate_res_t;

    // Scale a descriptor limit to a byte-granular last-offset value.
    function automatic logic [OFF_W-1:0] expand_limit(
        input logic [LIM_W-1:0] limit,
        input logic             gran
    );
        logic [OFF_W-1:0] scaled;
        scaled = {limit, {GRAN_SHIFT{1'b1}}};
        return gran ? scaled : OFF_W'(limit);
    endfunction

endpackage

// File: rtl/real_addr_gen.sv
module real_addr_gen
    import seg_xlate_pkg::*;
#(
    parameter int P_SEG_W   = SEG_W,
    parameter int P_SHIFT   = SEG_SHIFT,
    parameter int P_OFF_W   = REAL_OFF_W,
    parameter int P_ADDR_W  = ADDR_W
) (
    input  logic [P_SEG_W-1:0]  seg,
    input  logic [P_OFF_W-1:0]  off_lo,
    output logic [P_ADDR_W-1:0] addr
);
    localparam int SUM_W = P_SEG_W + P_SHIFT;

    logic [SUM_W-1:0] base_scaled;
    logic [SUM_W-1:0] sum_wrapped;

    always_comb begin
        base_scaled = {seg, {P_SHIFT{1'b0}}};
        // carry out of the top bit is dropped: 1 MiB wrap
        sum_wrapped = base_scaled + SUM_W'(off_lo);
        addr        = P_ADDR_W'(sum_wrapped);
    end

endmodule

// File: rtl/prot_limit_check.sv
module prot_limit_check
    import seg_xlate_pkg::*;
(
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    input  logic [OFF_W-1:0] off,
    output logic             over
);
    logic [OFF_W-1:0] last_ofs;

    always_comb begin
        last_ofs = expand_limit(limit, gran);
        over     = off > last_ofs;
    end

endmodule

// File: rtl/prot_addr_gen.sv
module prot_addr_gen
    import seg_xlate_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    // 32-bit wraparound sum
    assign addr = ADDR_W'(base + BASE_W'(off));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    mode_prot,
    input  logic [SEG_W-1:0]        seg_val,
    input  logic [OFF_W-1:0]        offset,
    input  logic [BASE_W-1:0]       desc_base,
    input  logic [LIM_W-1:0]        desc_limit,
    input  logic                    desc_gran,
    output logic [ADDR_W-1:0]       addr_out,
    output logic                    addr_valid,
    output logic                    limit_fault
);
    xlate_mode_e       mode;
    seg_desc_t         desc;
    logic [ADDR_W-1:0] real_addr;
    logic [ADDR_W-1:0] prot_addr;
    logic              over_limit;
    xlate_res_t        res_next;
    xlate_res_t        res_q;

    assign mode = xlate_mode_e'(mode_prot);
    assign desc = '{base: desc_base, limit: desc_limit, gran: desc_gran};

    real_addr_gen u_real (
        .seg    (seg_val),
        .off_lo (offset[REAL_OFF_W-1:0]),
        .addr   (real_addr)
    );

    prot_limit_check u_lim (
        .limit (desc.limit),
        .gran  (desc.gran),
        .off   (offset),
        .over  (over_limit)
    );

    prot_addr_gen u_prot (
        .base (desc.base),
        .off  (offset),
        .addr (prot_addr)
    );

    always_comb begin
        res_next = '0;
        if (req_valid) begin
            unique case (mode)
                XM_REAL: begin
                    res_next.addr = real_addr;
                    res_next.ok   = 1'b1;
                end
                XM_PROT: begin
                    if (over_limit) begin
                        res_next.fault = 1'b1;
                    end else begin
                        res_next.addr = prot_addr;
                        res_next.ok   = 1'b1;
                    end
                end
                default: res_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_next;
        end
    end

    assign addr_out    = res_q.addr;
    assign addr_valid  = res_q.ok;
    assign limit_fault = res_q.fault;

    // R8: valid and fault are exclusive
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(addr_valid && limit_fault));

    // R8: idle request leaves all outputs quiet
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!addr_valid && !limit_fault && addr_out == '0));

    // R2: 16-bit mode always yields a valid 20-bit address
    p_real_ok_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mode_prot) |=>
            (addr_valid && !limit_fault && addr_out[ADDR_W-1:REAL_W] == '0));

    // R5: offset within the unscaled limit is accepted in either granularity
    p_inlimit_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_prot && offset <= OFF_W'(desc_limit)) |=> addr_valid);

    // R6: granular descriptor accepts any offset whose page index is within limit
    p_gran_page_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_prot && desc_gran &&
         offset[OFF_W-1:GRAN_SHIFT] <= desc_limit) |=> addr_valid);

    // R7: a faulting result drives no address
    p_fault_addr_r7: assert property (@(posedge clk) disable iff (rst)
        limit_fault |-> (addr_out == '0));

endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
    import seg_xlate_pkg::*;

    typedef struct {
        logic [31:0] addr;
        logic        valid;
        logic        fault;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        mode_prot = 1'b0;
    logic [15:0] seg_val = '0;
    logic [31:0] offset = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic [31:0] addr_out;
    logic        addr_valid;
    logic        limit_fault;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    seg_xlate_unit u_seg_xlate_unit (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .mode_prot   (mode_prot),
        .seg_val     (seg_val),
        .offset      (offset),
        .desc_base   (desc_base),
        .desc_limit  (desc_limit),
        .desc_gran   (desc_gran),
        .addr_out    (addr_out),
        .addr_valid  (addr_valid),
        .limit_fault (limit_fault)
    );

    task automatic drive(input bit r, input bit v, input bit pm,
                         input logic [15:0] sg, input logic [31:0] of,
                         input logic [31:0] bs, input logic [19:0] lm,
                         input bit g, input string tag);
        exp_t e;
        logic [31:0] lin;
        logic [31:0] last;
        @(negedge clk);
        rst = r; req_valid = v; mode_prot = pm; seg_val = sg;
        offset = of; desc_base = bs; desc_limit = lm; desc_gran = g;
        e.addr = '0; e.valid = 1'b0; e.fault = 1'b0; e.tag = tag;
        if (!r && v) begin
            if (!pm) begin
                lin = ({16'h0, sg} << 4) + {16'h0, of[15:0]};
                e.addr  = lin & 32'h000F_FFFF;
                e.valid = 1'b1;
            end else begin
                last = g ? {lm, 12'hFFF} : {12'h000, lm};
                if (of > last) e.fault = 1'b1;
                else begin
                    e.addr  = bs + of;
                    e.valid = 1'b1;
                end
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic real_req(input logic [15:0] sg, input logic [31:0] of, input string tag);
        drive(1'b0, 1'b1, 1'b0, sg, of, 32'h5A5A_1234, 20'h00ABC, 1'b1, tag);
    endtask

    task automatic prot_req(input logic [31:0] bs, input logic [19:0] lm, input bit g,
                            input logic [31:0] of, input logic [15:0] sg, input string tag);
        drive(1'b0, 1'b1, 1'b1, sg, of, bs, lm, g, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 1'b1, 16'hBEEF, 32'h0000_0001, 32'h1000_0000, 20'hFFFFF, 1'b1, tag);
    endtask

    // monitor: sample mid high phase, well after the register update
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (addr_out !== e.addr || addr_valid !== e.valid || limit_fault !== e.fault) begin
                    n_fails++;
                    $display("FAIL %s: addr=%h valid=%b fault=%b expected addr=%h valid=%b fault=%b",
                             e.tag, addr_out, addr_valid, limit_fault, e.addr, e.valid, e.fault);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with a request present
        drive(1'b1, 1'b1, 1'b0, 16'h1000, 32'h23, '0, '0, 1'b0, "R1 reset with real req");
        drive(1'b1, 1'b1, 1'b1, 16'h0, 32'h0, 32'h1234_0000, 20'hFFFFF, 1'b1, "R1 reset with prot req");

        // R2: worked examples
        real_req(16'h1000, 32'h0000_0023, "R2 1000:0023");
        real_req(16'hAAF0, 32'h0000_0134, "R2 AAF0:0134");
        real_req(16'h1200, 32'h0000_FFF0, "R2 1200:FFF0");
        // R3: wrap past 1 MiB
        real_req(16'hFFFF, 32'h0000_0010, "R3 FFFF:0010 wraps");
        real_req(16'hFFFF, 32'h0000_FFFF, "R3 FFFF:FFFF wraps");
        // R4: upper offset and descriptor ignored
        drive(1'b0, 1'b1, 1'b0, 16'h1000, 32'hFFFF_0023, 32'hFFFF_FFFF, 20'h00000, 1'b0, "R4 upper offset ignored");
        drive(1'b0, 1'b1, 1'b0, 16'hAAF0, 32'h8000_0134, 32'h0000_0001, 20'h00001, 1'b1, "R4 descriptor ignored");

        // R5/R6/R7: descriptor example edges
        prot_req(32'h2300_0000, 20'h012FF, 1'b0, 32'h0000_12FF, 16'h0, "R6 g0 last byte");
        prot_req(32'h2300_0000, 20'h012FF, 1'b0, 32'h0000_1300, 16'h0, "R7 g0 one past limit");
        prot_req(32'h2300_0000, 20'h012FF, 1'b1, 32'h012F_FFFF, 16'h0, "R6 g1 last byte");
        prot_req(32'h2300_0000, 20'h012FF, 1'b1, 32'h0130_0000, 16'h0, "R7 g1 one past limit");
        prot_req(32'h2300_0000, 20'h012FF, 1'b1, 32'h0000_1300, 16'h0, "R6 g1 accepts g0 fault offset");
        prot_req(32'h2300_0000, 20'h012FF, 1'b1, 32'hFFFF_FFFF, 16'h0, "R7 g1 max offset");
        prot_req(32'h0010_0000, 20'h00000, 1'b0, 32'h0000_0000, 16'h0, "R7 zero limit offset zero");
        prot_req(32'h0010_0000, 20'h00000, 1'b0, 32'h0000_0001, 16'h0, "R7 zero limit offset one");
        // R5: 32-bit wrap
        prot_req(32'hFFFF_F000, 20'hFFFFF, 1'b1, 32'h0000_2000, 16'h0, "R5 32-bit wrap");
        prot_req(32'h0040_0000, 20'hFFFFF, 1'b0, 32'h0008_1234, 16'h0, "R5 plain sum");
        // R9: segment value ignored
        prot_req(32'h0040_0000, 20'hFFFFF, 1'b0, 32'h0008_1234, 16'hFFFF, "R9 seg ignored a");
        prot_req(32'h0040_0000, 20'hFFFFF, 1'b0, 32'h0008_1234, 16'h1357, "R9 seg ignored b");

        // R8: idle cycles clear outputs, back-to-back ordering
        idle("R8 idle after valid");
        prot_req(32'h2300_0000, 20'h012FF, 1'b0, 32'h0000_1300, 16'h0, "R8 fault before idle");
        idle("R8 idle after fault");
        real_req(16'h0001, 32'h0000_0001, "R8 back-to-back a");
        prot_req(32'h0000_0100, 20'h000FF, 1'b0, 32'h0000_00FF, 16'h0, "R8 back-to-back b");

        // R1: reset mid-stream
        drive(1'b1, 1'b1, 1'b1, 16'h0, 32'h0, 32'h9999_0000, 20'h00010, 1'b0, "R1 reset mid-stream");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [31:0] of;
            logic [19:0] lm;
            k  = $urandom % 8;
            lm = 20'($urandom);
            of = $urandom;
            if (k == 0) idle("R8 random idle");
            else if (k < 4) real_req(16'($urandom), of, "R2 random real");
            else if (k == 4) prot_req($urandom, lm, 1'b1, {lm, 12'($urandom)}, 16'($urandom), "R6 random in-page");
            else if (k == 5) prot_req($urandom, lm, 1'b0, {12'h0, lm} + {31'h0, of[0]}, 16'($urandom), "R7 random limit edge");
            else prot_req($urandom, lm, 1'($urandom), of, 16'($urandom), "R5 random prot");
        end

        idle("R8 final idle");
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule